// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Divider

This block divides one single-precision floating-point word by another. It develops the quotient with a radix-2 restoring recurrence that produces one bit per clock. The exponent difference is formed in the same cycle that the operands are accepted, so the exponent path runs alongside the recurrence. The recurrence runs to 26 quotient bits: 24 result bits, one bit to absorb the normalizing shift and one guard bit. The guard bit is the only input to rounding. Zero, infinity and NaN operands bypass the recurrence and produce fixed results.

A request is a one-cycle `start` pulse while `busy` is low. The operands are sampled at that clock edge. The controller is a three-state machine:

- **ST_IDLE** waits for a request.
- **ST_ITER** runs the recurrence.
- **ST_FINISH** rounds and packs the result.

The transitions are:

- **accept-normal**: ST_IDLE to ST_ITER.
- **accept-special**: ST_IDLE to ST_FINISH.
- **last-bit**: ST_ITER to ST_FINISH, after the 26th step.
- **retire**: ST_FINISH to ST_IDLE. On this edge `done` pulses and `result` is updated.

Top module: `fp_seq_divider`

## Requirements
- R1: For every non-NaN result, the sign bit (bit 31) is the XOR of the two operand sign bits.
- R2: For normal operands with biased exponents Ea and Eb, the result exponent is Ea−Eb+127 when the dividend significand is at least the divisor significand. Otherwise it is Ea−Eb+126 and the quotient is shifted left by one place.
- R3: The 24-bit normalized quotient is truncated. One is added to it when the next quotient bit below its LSB (the guard bit) is 1. No further quotient bits affect the result. Bits 22:0 carry the quotient without its leading one.
- R4: When the biased result exponent reaches 255 or more, the output is infinity: exponent field 0xFF and fraction 0. When it is 0 or less, the output is zero: exponent and fraction 0. In both cases the sign follows R1.
- R5: The result is the quiet NaN 0x7FC00000 in these cases: either operand is a NaN (exponent 0xFF, nonzero fraction), both operands are zero, or both operands are infinite.
- R6: An operand whose exponent field is 0 counts as zero. A non-NaN finite dividend over a zero divisor, or an infinite dividend over a finite divisor, gives infinity with sign per R1. A zero dividend over a nonzero divisor, or a finite dividend over an infinite divisor, gives zero with sign per R1.
- R7: For normal operands, `done` rises exactly 27 clock edges after the edge that samples `start`. For operands covered by R5 or R6, it rises 1 edge after.
- R8: `busy` is high from the accepting edge until the edge that raises `done`. A `start` seen while `busy` is high is ignored and does not alter the running operation.
- R9: `done` is high for exactly one cycle. `result` changes only on the edge that raises `done`.
- R10: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; honoured only while `busy` is low |
| dividend | input | 32 | Numerator word, sampled with `start` |
| divisor | input | 32 | Denominator word, sampled with `start` |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed quotient, held between completions |

## Verification
The bench runs a behavioural model of the handshake and of the arithmetic, and compares `busy`, `done` and `result` on every clock. Some faults change timing: a wrong iteration count or a stuck state would put `done` or `busy` off by at least one cycle, and this shows in the very cycle it happens. Other faults corrupt the data path: a mis-stepped remainder, a misread guard bit or a wrong exponent bias would leave a wrong `result` word. This shows on the completion edge of the affected operation, 27 cycles after it was accepted.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_FINISH
    } div_state_e;

    typedef enum logic [1:0] {
        SP_NONE,
        SP_NAN,
        SP_INF,
        SP_ZERO
    } special_e;

endpackage

// File: rtl/fpdiv_classify.sv
module fpdiv_classify
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output special_e     kind
);

    logic n_zero, n_inf, n_nan, d_zero, d_inf, d_nan;

    always_comb begin
        n_zero = (num[W-2 -: EXP_W] == '0);
        d_zero = (den[W-2 -: EXP_W] == '0);
        n_inf  = (num[W-2 -: EXP_W] == '1) && (num[FRAC_W-1:0] == '0);
        d_inf  = (den[W-2 -: EXP_W] == '1) && (den[FRAC_W-1:0] == '0);
        n_nan  = (num[W-2 -: EXP_W] == '1) && (num[FRAC_W-1:0] != '0);
        d_nan  = (den[W-2 -: EXP_W] == '1) && (den[FRAC_W-1:0] != '0);

        if (n_nan || d_nan || (n_zero && d_zero) || (n_inf && d_inf))
            kind = SP_NAN;
        else if (n_inf || d_zero)
            kind = SP_INF;
        else if (n_zero || d_inf)
            kind = SP_ZERO;
        else
            kind = SP_NONE;
    end

endmodule

// File: rtl/fpdiv_recur.sv
module fpdiv_recur #(
    parameter int SIG_W = 24,
    localparam int REM_W = SIG_W + 1,
    localparam int QW    = SIG_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] num_sig,
    input  logic [SIG_W-1:0] den_sig,
    output logic [QW-1:0]    quo
);

    logic [REM_W-1:0] rem_q;
    logic [SIG_W-1:0] den_q;
    logic [REM_W-1:0] trial;
    logic             qbit;

    // restoring step: subtract when the partial remainder covers the divisor
    always_comb begin
        qbit  = (rem_q >= {1'b0, den_q});
        trial = qbit ? (rem_q - {1'b0, den_q}) : rem_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo   <= '0;
        end else if (load) begin
            rem_q <= {1'b0, num_sig};
            den_q <= den_sig;
            quo   <= '0;
        end else if (step) begin
            rem_q <= {trial[REM_W-2:0], 1'b0};
            quo   <= {quo[QW-2:0], qbit};
        end
    end

endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int QW    = SIG_W + 2,
    localparam int ED_W  = EXP_W + 2
) (
    input  logic                   sign,
    input  logic signed [ED_W-1:0] ediff,
    input  logic [QW-1:0]          quo,
    output logic [W-1:0]           packed_word
);

    localparam logic signed [ED_W-1:0] BIAS_S = ED_W'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [ED_W-1:0] EMAX_S = ED_W'((1 << EXP_W) - 1);
    localparam logic signed [ED_W-1:0] ONE_S  = ED_W'(1);
    localparam logic signed [ED_W-1:0] ZERO_S = '0;

    logic                   top;
    logic [SIG_W-1:0]       sig;
    logic                   guard;
    logic [SIG_W-1:0]       sig_rnd;
    logic signed [ED_W-1:0] e_res;

    always_comb begin
        top   = quo[QW-1];
        sig   = top ? quo[QW-1:2] : quo[QW-2:1];
        guard = top ? quo[1] : quo[0];
        e_res = top ? (ediff + BIAS_S) : (ediff + BIAS_S - ONE_S);
        // a 24-by-24 quotient never shows all ones above a set guard bit
        sig_rnd = sig + SIG_W'(guard);

        if (e_res >= EMAX_S)
            packed_word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (e_res <= ZERO_S)
            packed_word = {sign, {(W-1){1'b0}}};
        else
            packed_word = {sign, e_res[EXP_W-1:0], sig_rnd[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fp_seq_divider.sv
module fp_seq_divider
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int QW    = SIG_W + 2;
    localparam int ED_W  = EXP_W + 2;
    localparam int CNT_W = $clog2(QW);

    div_state_e             state_q, state_d;
    special_e               kind_in, kind_q;
    logic                   sign_q;
    logic signed [ED_W-1:0] ediff_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [QW-1:0]          quo;
    logic [W-1:0]           rounded;
    logic                   accept;

    assign accept = (state_q == ST_IDLE) && start;
    assign busy   = (state_q != ST_IDLE);

    fpdiv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
        .num  (dividend),
        .den  (divisor),
        .kind (kind_in)
    );

    fpdiv_recur #(.SIG_W(SIG_W)) u_recur (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state_q == ST_ITER),
        .num_sig ({1'b1, dividend[FRAC_W-1:0]}),
        .den_sig ({1'b1, divisor[FRAC_W-1:0]}),
        .quo     (quo)
    );

    fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sign        (sign_q),
        .ediff       (ediff_q),
        .quo         (quo),
        .packed_word (rounded)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (kind_in == SP_NONE) ? ST_ITER : ST_FINISH;
            ST_ITER:   if (cnt_q == CNT_W'(QW - 1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= SP_NONE;
            sign_q  <= 1'b0;
            ediff_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            kind_q  <= kind_in;
            sign_q  <= dividend[W-1] ^ divisor[W-1];
            ediff_q <= $signed({2'b00, dividend[W-2 -: EXP_W]})
                     - $signed({2'b00, divisor[W-2 -: EXP_W]});
            cnt_q   <= '0;
        end else if (state_q == ST_ITER) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_FINISH) begin
                done <= 1'b1;
                unique case (kind_q)
                    SP_NAN:  result <= {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
                    SP_INF:  result <= {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                    SP_ZERO: result <= {sign_q, {(W-1){1'b0}}};
                    SP_NONE: result <= rounded;
                endcase
            end
        end
    end

endmodule

// File: rtl/fpdiv_checker.sv
module fpdiv_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int LAT    = 27,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int CW    = $clog2(LAT + 1) + 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);

    logic [CW-1:0] busy_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     busy_cycles <= '0;
        else if (!busy) busy_cycles <= '0;
        else            busy_cycles <= busy_cycles + 1'b1;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cycles == CW'(1) || busy_cycles == CW'(LAT)));

    p_nan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] != '0)
        |-> result == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}});

endmodule

bind fp_seq_divider fpdiv_checker #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .LAT    (FRAC_W + 4)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/test_fp_seq_divider.sv
module test_fp_seq_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic        busy, done;
    logic [31:0] result;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R10";
    bit    finished = 0;

    always #5 clk = ~clk;

    fp_seq_divider i_fp_seq_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dividend (a_in),
        .divisor  (b_in),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    // arithmetic reference from the requirements
    function automatic logic [31:0] ref_div(input logic [31:0] x, input logic [31:0] y);
        int ex, ey, e;
        longint mx, my, q;
        logic s, xz, yz, xi, yi, xn, yn;
        logic [23:0] sig;
        logic g;
        s  = x[31] ^ y[31];
        ex = int'(x[30:23]);
        ey = int'(y[30:23]);
        xz = (ex == 0);
        yz = (ey == 0);
        xi = (ex == 255) && (x[22:0] == 0);
        yi = (ey == 255) && (y[22:0] == 0);
        xn = (ex == 255) && (x[22:0] != 0);
        yn = (ey == 255) && (y[22:0] != 0);
        if (xn || yn || (xz && yz) || (xi && yi)) return 32'h7FC0_0000;
        if (xi || yz) return {s, 8'hFF, 23'd0};
        if (xz || yi) return {s, 31'd0};
        mx = longint'({1'b1, x[22:0]});
        my = longint'({1'b1, y[22:0]});
        q  = (mx << 25) / my;
        if (q >= (64'sd1 << 25)) begin
            sig = q[25:2]; g = q[1]; e = ex - ey + 127;
        end else begin
            sig = q[24:1]; g = q[0]; e = ex - ey + 126;
        end
        sig = sig + 24'(g);
        if (e >= 255) return {s, 8'hFF, 23'd0};
        if (e <= 0)   return {s, 31'd0};
        return {s, 8'(e), sig[22:0]};
    endfunction

    function automatic bit is_special(input logic [31:0] x, input logic [31:0] y);
        return (x[30:23] == 0) || (y[30:23] == 0) || (x[30:23] == 8'hFF) || (y[30:23] == 8'hFF);
    endfunction

    // cycle-level handshake model
    logic        m_busy = 0, m_done = 0;
    int          m_left = 0;
    logic [31:0] m_pend = '0, m_res = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_left <= 0; m_res <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1;
                    m_left <= is_special(a_in, b_in) ? 0 : 26;
                    m_pend <= ref_div(a_in, b_in);
                end
            end else if (m_left == 0) begin
                m_busy <= 0;
                m_done <= 1;
                m_res  <= m_pend;
            end else begin
                m_left <= m_left - 1;
            end
        end
    end

    always @(negedge clk) if (!finished) begin
        n_cmp += 3;
        if (busy !== m_busy) begin
            n_bad++;
            $display("FAIL R8 busy: actual %0b expected %0b at %0t", busy, m_busy, $time);
        end
        if (done !== m_done) begin
            n_bad++;
            $display("FAIL R7 done: actual %0b expected %0b at %0t", done, m_done, $time);
        end
        if (result !== m_res) begin
            n_bad++;
            $display("FAIL %s result: actual %h expected %h at %0t", cur_req, result, m_res, $time);
        end
    end

    task automatic issue(input logic [31:0] x, input logic [31:0] y, input string tag);
        @(negedge clk);
        cur_req = tag;
        a_in = x; b_in = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] seed;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;                                   // R10 reset state compared above
        repeat (2) @(negedge clk);

        issue(32'h4040_0000, 32'h3FC0_0000, "R2");      // 3 / 1.5 = 2, no shift
        issue(32'h3F80_0000, 32'h4040_0000, "R3");      // 1/3, guard rounds up
        issue(32'h4000_0000, 32'h4040_0000, "R3");      // 2/3
        issue(32'h40E0_0000, 32'h4040_0000, "R3");      // 7/3
        issue(32'hC0C0_0000, 32'h4000_0000, "R1");      // -6 / 2
        issue(32'h4120_0000, 32'hBDCC_CCCD, "R1");      // 10 / -0.1
        issue(32'hBF80_0000, 32'hC0A0_0000, "R1");      // -1 / -5
        issue(32'h3F00_0000, 32'h3FFF_FFFF, "R2");      // shifted path
        issue(32'h7F00_0000, 32'h3F00_0000, "R4");      // overflow to inf
        issue(32'h7F00_0000, 32'h3F80_0000, "R4");      // largest exponent stays finite
        issue(32'h0080_0000, 32'h4000_0000, "R4");      // underflow to zero
        issue(32'h8080_0000, 32'h4000_0000, "R4");      // signed underflow
        issue(32'h0000_0000, 32'h0000_0000, "R5");      // 0/0
        issue(32'h7F80_0000, 32'hFF80_0000, "R5");      // inf/inf
        issue(32'h7FC0_0001, 32'h3F80_0000, "R5");      // NaN operand
        issue(32'h3F80_0000, 32'h0000_0000, "R6");      // x/0
        issue(32'hBF80_0000, 32'h0000_0000, "R6");      // -x/0
        issue(32'h0000_0000, 32'h4040_0000, "R6");      // 0/x
        issue(32'hFF80_0000, 32'h4000_0000, "R6");      // -inf/x
        issue(32'h4000_0000, 32'hFF80_0000, "R6");      // x/-inf
        issue(32'h0000_0001, 32'h3F80_0000, "R6");      // tiny operand counts as zero

        // R8: a second start while busy must be ignored
        @(negedge clk);
        cur_req = "R8";
        a_in = 32'h4120_0000; b_in = 32'h4040_0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        a_in = 32'h3F80_0000; b_in = 32'h0000_0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        a_in = '0; b_in = '0;
        repeat (30) @(negedge clk);

        // R3: spread of normal operands
        seed = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] x, y;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            x = {seed[31], 8'(64 + seed[30:24]), seed[22:0]};
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            y = {seed[31], 8'(64 + seed[30:24]), seed[22:0]};
            issue(x, y, "R3");
        end

        // R7/R9: back-to-back special then normal
        issue(32'h7F80_0000, 32'h3F80_0000, "R7");
        issue(32'h3FC0_0000, 32'h3F80_0000, "R9");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule